// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM burst, one beat per clock. A controller strobes `start` together with a start column, a length code and a burst type. From the following cycle the block presents one column per cycle with a valid flag, and it raises a last-beat flag on the final beat of a finite burst. All beats of a finite burst stay inside the block of columns that is aligned to the burst length and contains the start column. Within that block the low column bits either count upward and wrap, or follow an XOR order against the beat number. The upper column bits never change during a finite burst.

In full-page mode the column counts upward through the whole row, wraps from the top column back to zero, and carries on until it is stopped. A `stop` input ends any burst early. A fresh `start` during a burst drops the beats that remain and begins a complete new burst. Codes that the block does not support raise an error flag, and the request is then run as a one-beat burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released, `col_valid`, `last_beat` and `mode_err` are low until the first `start`.
- R2: When `start` is high at a rising edge, the next cycle shows `col_valid` high and `col` equal to the sampled `start_col`.
- R3: In sequential mode (`burst_type` = 0) with length L, beat k outputs the aligned block base plus ((start_col mod L) + k) mod L. For example, length 4 from column 1 gives 1, 2, 3, 0.
- R4: In interleave mode (`burst_type` = 1), beat k outputs the block base plus ((start_col mod L) XOR k). For example, length 8 from column 2 gives 2, 3, 0, 1, 6, 7, 4, 5.
- R5: `len_code` 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. `len_code` 7 selects full page. A finite burst keeps `col_valid` high for exactly L consecutive cycles.
- R6: `last_beat` is high exactly on the final beat of a finite burst, and `col_valid` falls in the cycle after that beat.
- R7: In full page, the column increments by one each cycle modulo 256, and `last_beat` is never raised. The burst continues past 256 beats until stopped.
- R8: If `stop` is high at an edge without `start`, `col_valid` is low in the next cycle. `stop` while idle has no effect.
- R9: A `start` during an active burst discards the remaining beats and begins a full-length burst from the new start column and mode.
- R10: If `start` and `stop` are high at the same edge, the start takes effect and the stop is ignored.
- R11: `len_code` 4, 5 or 6, or `len_code` 7 with `burst_type` = 1, sets `mode_err` and runs a one-beat burst at `start_col` with `last_beat` high. `mode_err` holds until the next `start`, and a supported request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new burst (single-cycle strobe) |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code |
| burst_type | input | 1 | 0 sequential, 1 interleave |
| stop | input | 1 | End the current burst early |
| col | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Final beat of a finite burst |
| mode_err | output | 1 | Last request used an unsupported code |

## Verification
Two events can land on the same edge and compete: a new start and a stop, and a new start and the natural end of a burst. The bench drives `start` together with `stop` in the middle of a burst and expects the new burst to begin at once from the new column. It also issues a restart on the cycle that shows `last_beat`. In that case the old burst must not close, and the new burst must run its full length. Stopping a full-page burst after it has wrapped past column 255 checks that the stop path works at any point in the row.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic {BT_SEQ = 1'b0, BT_INTLV = 1'b1} burst_type_e;
  typedef enum logic [2:0] {
    LC_1 = 3'd0, LC_2 = 3'd1, LC_4 = 3'd2, LC_8 = 3'd3, LC_FULL = 3'd7
  } len_code_e;
  localparam int LEN_W = 3;
endpackage

// File: rtl/bsg_mode_dec.sv
module bsg_mode_dec
  import bsg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_W-1:0] len_code,
  input  logic             intlv,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             err
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  always_comb begin
    mask = '0;
    full = 1'b0;
    err  = 1'b0;
    case (len_code)
      LC_1, LC_2, LC_4, LC_8: mask = (ONE << len_code[1:0]) - ONE;
      LC_FULL: begin
        if (intlv) err = 1'b1;
        else begin
          mask = '1;
          full = 1'b1;
        end
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/bsg_beat_ctl.sv
module bsg_beat_ctl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             err_in,
  input  logic             intlv_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             intlv,
  output logic             err,
  output logic             last
);
  logic end_now;

  assign last    = active && !full && (beat == mask);
  assign end_now = active && (stop || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      base   <= '0;
      mask   <= '0;
      full   <= 1'b0;
      intlv  <= 1'b0;
      err    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
      base   <= start_col;
      mask   <= mask_in;
      full   <= full_in;
      intlv  <= intlv_in;
      err    <= err_in;
    end else if (end_now) begin
      active <= 1'b0;
    end else if (active) begin
      beat <= beat + COL_W'(1);
    end
  end

  // R6: a burst that shows its last beat closes on the next edge unless restarted
  a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> !active);
  // R8: stop without start ends the burst
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    active && stop && !start |=> !active);
  // R9: every start restarts the beat count
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && beat == '0);
  // R7: full page never flags a last beat
  a_r7_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !last);
endmodule

// File: rtl/bsg_col_map.sv
module bsg_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             intlv,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] seq_col(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + k) & m);
  endfunction

  function automatic logic [COL_W-1:0] il_col(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (b & ~m) | ((b ^ k) & m);
  endfunction

  assign col = intlv ? il_col(base, beat, mask) : seq_col(base, beat, mask);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import bsg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_code,
  input  logic             burst_type,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             last_beat,
  output logic             mode_err
);
  logic [COL_W-1:0] dec_mask, beat_q, base_q, mask_q;
  logic             dec_full, dec_err, active_q, full_q, intlv_q, err_q, last_w;

  bsg_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code (len_code),
    .intlv    (burst_type),
    .mask     (dec_mask),
    .full     (dec_full),
    .err      (dec_err)
  );

  bsg_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .start_col(start_col),
    .mask_in  (dec_mask),
    .full_in  (dec_full),
    .err_in   (dec_err),
    .intlv_in (burst_type),
    .active   (active_q),
    .beat     (beat_q),
    .base     (base_q),
    .mask     (mask_q),
    .full     (full_q),
    .intlv    (intlv_q),
    .err      (err_q),
    .last     (last_w)
  );

  bsg_col_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat_q),
    .mask (mask_q),
    .intlv(intlv_q),
    .col  (col)
  );

  assign col_valid = active_q;
  assign last_beat = last_w;
  assign mode_err  = err_q;

  // R2: first beat shows the sampled start column
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col == $past(start_col));
  // R3 / R4: every beat stays in the aligned block of the start column
  a_r3_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> ((col & ~mask_q) == (base_q & ~mask_q)));
  // R10: start wins over a coincident stop
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start && stop |=> col_valid);
  // R11: unsupported code gives a one-beat burst with the error flag
  a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    start && dec_err |=> last_beat && mode_err);
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       burst_type = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       col_valid, last_beat, mode_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .burst_type(burst_type), .stop(stop),
    .col(col), .col_valid(col_valid), .last_beat(last_beat), .mode_err(mode_err)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected column: aligned block plus offset within it
  function automatic int exp_col(int c0, int L, bit il, int k);
    int blk = c0 - (c0 % L);
    int off = il ? ((c0 % L) ^ k) : (((c0 % L) + k) % L);
    return blk + off;
  endfunction

  task automatic issue(int c0, int code, bit il, bit stp);
    start_col = 8'(c0); len_code = 3'(code); burst_type = il; start = 1; stop = stp;
    @(negedge clk);
    start = 0; stop = 0;
  endtask

  // checks L beats from the current negedge, then idle
  task automatic walk(string req, int c0, int L, bit il);
    for (int k = 0; k < L; k++) begin
      chk({req, " col"}, col, exp_col(c0, L, il, k));
      chk({req, " valid"}, col_valid, 1);
      chk({req, " R6 last"}, last_beat, (k == L - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " R5 end"}, col_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid in reset", col_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last_beat, 0);
    chk("R1 err", mode_err, 0);
  endtask

  task automatic t_lengths();
    issue(8'h31, 0, 0, 0); chk("R2 first", col, 8'h31); walk("R5 len1", 8'h31, 1, 0);
    issue(8'h31, 1, 0, 0); walk("R5 len2", 8'h31, 2, 0);
    issue(8'h41, 2, 0, 0); walk("R3 seq4", 8'h41, 4, 0);
    issue(8'h1D, 3, 0, 0); walk("R3 seq8", 8'h1D, 8, 0);
    issue(8'h02, 3, 1, 0); walk("R4 il8", 8'h02, 8, 1);
    issue(8'h97, 2, 1, 0); walk("R4 il4", 8'h97, 4, 1);
  endtask

  task automatic t_full();
    issue(8'hF0, 7, 0, 0);
    for (int k = 0; k < 300; k++) begin
      chk("R7 col", col, (8'hF0 + k) % 256);
      chk("R7 last", last_beat, 0);
      if (k == 299) stop = 1;
      @(negedge clk);
    end
    stop = 0;
    chk("R8 stop full", col_valid, 0);
  endtask

  task automatic t_stop();
    issue(8'h20, 3, 0, 0);
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 stop mid", col_valid, 0);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 idle stop", col_valid, 0);
    issue(8'h55, 1, 0, 0);
    chk("R8 later start", col, 8'h55);
    walk("R8 after", 8'h55, 2, 0);
  endtask

  task automatic t_restart();
    issue(8'h10, 3, 0, 0);
    @(negedge clk); @(negedge clk);
    issue(8'h45, 2, 1, 0);
    walk("R9 restart", 8'h45, 4, 1);
    issue(8'h60, 1, 0, 0);
    chk("R9 last seen", last_beat, 0);
    @(negedge clk);
    chk("R9 on last", last_beat, 1);
    issue(8'h6B, 2, 0, 0);
    walk("R9 at last", 8'h6B, 4, 0);
  endtask

  task automatic t_same_cycle();
    issue(8'h80, 3, 0, 0);
    @(negedge clk);
    issue(8'hA6, 3, 1, 1);
    walk("R10 start+stop", 8'hA6, 8, 1);
  endtask

  task automatic t_errors();
    issue(8'h3C, 5, 0, 0);
    chk("R11 err code5", mode_err, 1);
    walk("R11 one beat", 8'h3C, 1, 0);
    chk("R11 err held", mode_err, 1);
    issue(8'h77, 7, 1, 0);
    chk("R11 err il full", mode_err, 1);
    walk("R11 il full", 8'h77, 1, 0);
    issue(8'h77, 2, 0, 0);
    chk("R11 err cleared", mode_err, 0);
    walk("R11 after", 8'h77, 4, 0);
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_full();
    t_stop();
    t_restart();
    t_same_cycle();
    t_errors();
    finish_run();
  end
endmodule